// File: doc/BRIEF.md
# Banked Memory Mapper with Write Protection

The mapper turns a 16-bit CPU address into a physical page in one of three memories: a small ROM, a main RAM of up to 256 pages of 16 KB (4 MB), and a video RAM. The address space has four 16 KB slots, selected by the two top address bits. In normal mode the lowest slot shows a ROM page. The second and third slots show fixed RAM pages 5 and 2. The top slot shows a RAM page chosen by the paging control. In the all-RAM mode, four fixed slot layouts are chosen by two control bits.

Four extra control bytes add features on top of this map. Any ROM page can be replaced by one of RAM pages 12 to 15, and those replacement pages can be made read-only. Video RAM shadows CPU writes to pages 4 to 7, and each region of that shadow has its own write disable. Main RAM writes to pages 4 to 7 can also be disabled. Reads of pages 4 to 7 can be taken from video RAM. High page-number bits widen the main RAM to 4 MB. A blocked write is dropped without any stall or error. Every result is registered, so the outputs describe the request that was present at the previous clock edge.

Top module: `bank_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, all chip selects and write enables are low at the next edge.
- R2: When `pg_sys[0]` = 0 (normal mode), the slots map as follows. Slot 0 (addresses 0x0000-0x3FFF) is ROM page {`pg_sys[2]`,`pg_main[4]`}. Slot 1 is RAM page 5. Slot 2 is RAM page 2. Slot 3 is RAM page {`pg_ext[7:3]`,`pg_main[2:0]`}.
- R3: In normal mode, when `pg_ovl[n]` is 1 and ROM page n is selected in slot 0, the access goes to RAM page 12+n instead. When the overlay bit of the selected page is clear, ROM page n stays in place.
- R4: When `pg_ovl[4]` = 1, a write to a RAM page that is standing in for ROM keeps `ram_cs` high and drives `ram_we` low.
- R5: When `pg_sys[0]` = 1 (all-RAM mode), `pg_sys[2:1]` selects the pages of slots 0 to 3. Value 0 gives 0,1,2,3. Value 1 gives 4,5,6,7. Value 2 gives 4,5,6,3. Value 3 gives 4,7,6,3. In slot 1, `pg_ext[7:3]` forms the page bits 7 to 3.
- R6: When `pg_vid[4]` = 1, a write to main RAM pages 4-7 drives `ram_we` low.
- R7: A write to pages 4-7 also selects video RAM (`vram_cs`). `vram_we` is dropped in these cases: for page 5 at offsets below 0x2000 when `pg_vid[0]` is set; for page 7 at offsets below 0x2000 when `pg_vid[1]` is set; for pages 5 and 7 at offsets 0x2000 and above when `pg_vid[2]` is set; for pages 4 and 6 when `pg_vid[3]` is set.
- R8: When `pg_vid[5]` = 1, a read of pages 4-7 asserts `vram_cs` and not `ram_cs`. Reads of other pages are not affected.
- R9: A write to a ROM page asserts no chip select and no write enable.
- R10: A cycle with neither `cpu_rd` nor `cpu_wr` asserts no chip select at the next edge. A read always asserts exactly one chip select.
- R11: `page_off` equals the low 14 bits of the requested address.
- R12: `pg_ext[7:3]` has no effect on pages in slots 0 and 2, or on slot 1 in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| pg_main | input | 8 | Primary paging control (top page, ROM low bit) |
| pg_sys | input | 8 | System paging control (mode, ROM high bit, layout) |
| pg_ovl | input | 8 | ROM overlay enables and overlay protect |
| pg_vid | input | 8 | Video write disables, main RAM protect, read redirect |
| pg_ext | input | 8 | Extended page bits 7..3 |
| rom_cs | output | 1 | ROM select |
| ram_cs | output | 1 | Main RAM select |
| vram_cs | output | 1 | Video RAM select |
| ram_we | output | 1 | Main RAM write enable |
| vram_we | output | 1 | Video RAM write enable |
| phys_page | output | 8 | Physical page number |
| page_off | output | 14 | Offset within the page |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together, and that the control bytes change only between clock edges, together with the request. The stimulus applies every request, control byte included, at the falling edge. It never raises both strobes, so each registered result belongs to exactly one request. The expected outputs are computed from the page tables and protection rules above, one cycle after each request.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2
  } tgt_e;

  // Page layout of the all-RAM mode, per layout code and slot.
  function automatic logic [2:0] allram_page(input logic [1:0] layout,
                                             input logic [1:0] slot);
    logic [2:0] p;
    case (layout)
      2'd0:    p = {1'b0, slot};
      2'd1:    p = {1'b1, slot};
      2'd2:    p = (slot == 2'd3) ? 3'd3 : {1'b1, slot};
      default: begin
        case (slot)
          2'd0:    p = 3'd4;
          2'd1:    p = 3'd7;
          2'd2:    p = 3'd6;
          default: p = 3'd3;
        endcase
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mapper_slot_decode.sv
module mapper_slot_decode
  import bank_mapper_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic [1:0]        slot,
  input  logic [7:0]        ctl_main,
  input  logic [7:0]        ctl_sys,
  input  logic [7:0]        ctl_ovl,
  input  logic [7:0]        ctl_ext,
  output tgt_e              tgt,
  output logic [PAGE_W-1:0] page,
  output logic              ovl_hit
);
  localparam int HI_W = PAGE_W - 3;

  logic [1:0]      rom_idx;
  logic [HI_W-1:0] hi_bits;
  logic [2:0]      ram_base;

  assign rom_idx  = {ctl_sys[2], ctl_main[4]};
  assign hi_bits  = ctl_ext[PAGE_W-1:3];
  assign ram_base = allram_page(ctl_sys[2:1], slot);

  always_comb begin
    tgt     = TGT_RAM;
    page    = '0;
    ovl_hit = 1'b0;
    if (!ctl_sys[0]) begin
      case (slot)
        2'd0: begin
          if (ctl_ovl[rom_idx]) begin
            ovl_hit = 1'b1;
            page    = PAGE_W'(4'd12 + {2'b00, rom_idx});
          end else begin
            tgt  = TGT_ROM;
            page = PAGE_W'(rom_idx);
          end
        end
        2'd1:    page = PAGE_W'(3'd5);
        2'd2:    page = PAGE_W'(3'd2);
        default: page = {hi_bits, ctl_main[2:0]};
      endcase
    end else begin
      if (slot == 2'd1) page = {hi_bits, ram_base};
      else              page = PAGE_W'(ram_base);
    end
  end

endmodule

// File: rtl/mapper_wr_guard.sv
module mapper_wr_guard
  import bank_mapper_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tgt_e              tgt,
  input  logic [PAGE_W-1:0] page,
  input  logic              ovl_hit,
  input  logic              upper_half,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        ctl_ovl,
  input  logic [7:0]        ctl_vid,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              vram_cs_n,
  output logic              ram_we_n,
  output logic              vram_we_n
);
  logic shared_bank;
  logic region_off;
  logic ram_locked;

  assign shared_bank = (page[PAGE_W-1:2] == (PAGE_W-2)'(1));
  assign ram_locked  = (ovl_hit && ctl_ovl[4]) || (shared_bank && ctl_vid[4]);

  always_comb begin
    case (page[1:0])
      2'b01:   region_off = upper_half ? ctl_vid[2] : ctl_vid[0];
      2'b11:   region_off = upper_half ? ctl_vid[2] : ctl_vid[1];
      default: region_off = ctl_vid[3];
    endcase
  end

  always_comb begin
    rom_cs_n  = 1'b0;
    ram_cs_n  = 1'b0;
    vram_cs_n = 1'b0;
    ram_we_n  = 1'b0;
    vram_we_n = 1'b0;
    if (rd && tgt == TGT_ROM) begin
      rom_cs_n = 1'b1;
    end else if (rd && tgt == TGT_RAM) begin
      if (shared_bank && ctl_vid[5]) vram_cs_n = 1'b1;
      else                           ram_cs_n  = 1'b1;
    end else if (wr && tgt == TGT_RAM) begin
      ram_cs_n = 1'b1;
      ram_we_n = !ram_locked;
      if (shared_bank) begin
        vram_cs_n = 1'b1;
        vram_we_n = !region_off;
      end
    end
  end

  // Overlay RAM marked read-only never takes a write.
  assert_ovl_protect_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && tgt == TGT_RAM && page[PAGE_W-1:2] == (PAGE_W-2)'(3) && ovl_hit && ctl_ovl[4])
      |-> (ram_cs_n && !ram_we_n));

  // Main RAM pages 4-7 locked against writes.
  assert_main_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && page >= PAGE_W'(4) && page <= PAGE_W'(7) && ctl_vid[4]) |-> !ram_we_n);

  // Redirected reads never touch main RAM.
  assert_redirect_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && tgt == TGT_RAM && page >= PAGE_W'(4) && page <= PAGE_W'(7) && ctl_vid[5])
      |-> (vram_cs_n && !ram_cs_n));

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        pg_main,
  input  logic [7:0]        pg_sys,
  input  logic [7:0]        pg_ovl,
  input  logic [7:0]        pg_vid,
  input  logic [7:0]        pg_ext,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              vram_cs,
  output logic              ram_we,
  output logic              vram_we,
  output logic [PAGE_W-1:0] phys_page,
  output logic [ADDR_W-3:0] page_off
);
  localparam int OFF_W = ADDR_W - 2;

  tgt_e              dec_tgt;
  logic [PAGE_W-1:0] dec_page;
  logic              dec_ovl;
  logic              n_rom_cs, n_ram_cs, n_vram_cs, n_ram_we, n_vram_we;

  mapper_slot_decode #(.PAGE_W(PAGE_W)) u_decode (
    .slot     (cpu_addr[ADDR_W-1:ADDR_W-2]),
    .ctl_main (pg_main),
    .ctl_sys  (pg_sys),
    .ctl_ovl  (pg_ovl),
    .ctl_ext  (pg_ext),
    .tgt      (dec_tgt),
    .page     (dec_page),
    .ovl_hit  (dec_ovl)
  );

  mapper_wr_guard #(.PAGE_W(PAGE_W)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .tgt        (dec_tgt),
    .page       (dec_page),
    .ovl_hit    (dec_ovl),
    .upper_half (cpu_addr[OFF_W-1]),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .ctl_ovl    (pg_ovl),
    .ctl_vid    (pg_vid),
    .rom_cs_n   (n_rom_cs),
    .ram_cs_n   (n_ram_cs),
    .vram_cs_n  (n_vram_cs),
    .ram_we_n   (n_ram_we),
    .vram_we_n  (n_vram_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs    <= 1'b0;
      ram_cs    <= 1'b0;
      vram_cs   <= 1'b0;
      ram_we    <= 1'b0;
      vram_we   <= 1'b0;
      phys_page <= '0;
      page_off  <= '0;
    end else begin
      rom_cs    <= n_rom_cs;
      ram_cs    <= n_ram_cs;
      vram_cs   <= n_vram_cs;
      ram_we    <= n_ram_we;
      vram_we   <= n_vram_we;
      phys_page <= dec_page;
      page_off  <= cpu_addr[OFF_W-1:0];
    end
  end

  // Input rule: one strobe at a time.
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd && cpu_wr));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> !(rom_cs || ram_cs || vram_cs));

  assert_read_selects_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr) |=> $countones({rom_cs, ram_cs, vram_cs}) == 1);

  assert_rom_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> (!ram_we && !vram_we && !ram_cs && !vram_cs));

  assert_we_needs_cs_R7: assert property (@(posedge clk) disable iff (rst)
    (!ram_we || ram_cs) && (!vram_we || vram_cs));

  assert_offset_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || cpu_wr) |=> page_off == $past(cpu_addr[OFF_W-1:0]));

endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  pg_main, pg_sys, pg_ovl, pg_vid, pg_ext;
  logic        rom_cs, ram_cs, vram_cs, ram_we, vram_we;
  logic [7:0]  phys_page;
  logic [13:0] page_off;

  always #2 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .pg_main(pg_main), .pg_sys(pg_sys), .pg_ovl(pg_ovl), .pg_vid(pg_vid), .pg_ext(pg_ext),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .vram_cs(vram_cs), .ram_we(ram_we),
    .vram_we(vram_we), .phys_page(phys_page), .page_off(page_off)
  );

  typedef struct {
    logic [4:0]  sel;   // rom, ram, vram, ram_we, vram_we
    logic [7:0]  page;
    logic [13:0] off;
    logic        full;  // compare page and offset too
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  logic [7:0] s_main, s_sys, s_ovl, s_vid, s_ext;

  function automatic exp_t model(input logic [15:0] a, input logic r, input logic w,
                                 input string tag);
    exp_t e;
    logic [2:0] tbl [4][4];
    logic [1:0] idx;
    logic       is_rom, locked_ovl, mid;
    logic [7:0] pg;
    logic [2:0] b;
    tbl[0] = '{3'd0, 3'd1, 3'd2, 3'd3};
    tbl[1] = '{3'd4, 3'd5, 3'd6, 3'd7};
    tbl[2] = '{3'd4, 3'd5, 3'd6, 3'd3};
    tbl[3] = '{3'd4, 3'd7, 3'd6, 3'd3};
    is_rom = 1'b0; locked_ovl = 1'b0;
    idx = {s_sys[2], s_main[4]};
    if (s_sys[0]) begin
      b  = tbl[s_sys[2:1]][a[15:14]];
      pg = (a[15:14] == 2'd1) ? {s_ext[7:3], b} : {5'd0, b};
    end else if (a[15:14] == 2'd0) begin
      if (s_ovl[idx]) begin pg = 8'd12 + {6'd0, idx}; locked_ovl = s_ovl[4]; end
      else begin pg = {6'd0, idx}; is_rom = 1'b1; end
    end else if (a[15:14] == 2'd1) pg = 8'd5;
    else if (a[15:14] == 2'd2) pg = 8'd2;
    else pg = {s_ext[7:3], s_main[2:0]};
    mid = (pg >= 8'd4 && pg <= 8'd7);
    e.sel = 5'b0;
    if (r) begin
      if (is_rom) e.sel[4] = 1'b1;
      else if (mid && s_vid[5]) e.sel[2] = 1'b1;
      else e.sel[3] = 1'b1;
    end else if (w && !is_rom) begin
      e.sel[3] = 1'b1;
      e.sel[1] = !(locked_ovl || (mid && s_vid[4]));
      if (mid) begin
        e.sel[2] = 1'b1;
        if (pg == 8'd4 || pg == 8'd6) e.sel[0] = !s_vid[3];
        else if (a[13])               e.sel[0] = !s_vid[2];
        else if (pg == 8'd5)          e.sel[0] = !s_vid[0];
        else                          e.sel[0] = !s_vid[1];
      end
    end
    e.page = pg;
    e.off  = a[13:0];
    e.full = r || w;
    e.tag  = tag;
    return e;
  endfunction

  task automatic issue(input logic [15:0] a, input logic r, input logic w, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w;
    pg_main = s_main; pg_sys = s_sys; pg_ovl = s_ovl; pg_vid = s_vid; pg_ext = s_ext;
    q.push_back(model(a, r, w, tag));
  endtask

  task automatic ctl(input logic [7:0] m, input logic [7:0] s, input logic [7:0] o,
                     input logic [7:0] v, input logic [7:0] x);
    s_main = m; s_sys = s; s_ovl = o; s_vid = v; s_ext = x;
  endtask

  // Monitor: compares one expected item per cycle after the registering edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = q.pop_front();
      got = {rom_cs, ram_cs, vram_cs, ram_we, vram_we};
      total++;
      if (got !== e.sel || (e.full && (phys_page !== e.page || page_off !== e.off))) begin
        bad++;
        $display("FAIL %s: sel=%b page=%0d off=%h expected sel=%b page=%0d off=%h",
                 e.tag, got, phys_page, page_off, e.sel, e.page, e.off);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    bad++;
    $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    ctl(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    pg_main = 0; pg_sys = 0; pg_ovl = 0; pg_vid = 0; pg_ext = 0;
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = 16'h4000;
    repeat (3) @(negedge clk);
    total++;
    if ({rom_cs, ram_cs, vram_cs, ram_we, vram_we} !== 5'b0) begin
      bad++;
      $display("FAIL R1: sel=%b expected 00000", {rom_cs, ram_cs, vram_cs, ram_we, vram_we});
    end
    cpu_rd = 1'b0; rst = 1'b0;

    // R2 normal map, ROM selection from both bits
    ctl(8'h10, 8'h00, 8'h00, 8'h00, 8'h00); issue(16'h0123, 1, 0, "R2 rom1");
    ctl(8'h10, 8'h04, 8'h00, 8'h00, 8'h00); issue(16'h3FFF, 1, 0, "R2 rom3");
    ctl(8'h06, 8'h00, 8'h00, 8'h00, 8'h00); issue(16'h4001, 1, 0, "R2 slot1");
    issue(16'h8abc, 1, 0, "R2 slot2");
    issue(16'hC010, 1, 0, "R2 slot3");
    ctl(8'h03, 8'h00, 8'h00, 8'h00, 8'h28); issue(16'hD000, 1, 0, "R2 ext slot3");
    ctl(8'h07, 8'h00, 8'h00, 8'h00, 8'hF8); issue(16'hFFFF, 1, 0, "R2 ext full");
    // R12 ext ignored elsewhere
    issue(16'h0000, 1, 0, "R12 slot0");
    issue(16'h4000, 1, 0, "R12 slot1");
    issue(16'h8000, 1, 0, "R12 slot2");
    // R3 overlay
    ctl(8'h10, 8'h00, 8'h02, 8'h00, 8'h00); issue(16'h0200, 1, 0, "R3 ovl read");
    issue(16'h0200, 0, 1, "R3 ovl write");
    ctl(8'h10, 8'h00, 8'h01, 8'h00, 8'h00); issue(16'h0200, 1, 0, "R3 other bit");
    ctl(8'h10, 8'h04, 8'h08, 8'h00, 8'h00); issue(16'h2000, 1, 0, "R3 page15");
    // R4 overlay protect
    ctl(8'h10, 8'h00, 8'h12, 8'h00, 8'h00); issue(16'h0200, 0, 1, "R4 locked");
    // R9 rom write
    ctl(8'h00, 8'h00, 8'h10, 8'h00, 8'h00); issue(16'h0010, 0, 1, "R9 rom write");
    // R5 all-RAM layouts
    for (int l = 0; l < 4; l++) begin
      for (int s = 0; s < 4; s++) begin
        ctl(8'h00, {5'd0, 2'(l), 1'b1}, 8'h00, 8'h00, 8'h00);
        issue({2'(s), 14'h0155}, 1, 0, "R5 layout");
      end
    end
    ctl(8'h00, 8'h03, 8'h00, 8'h00, 8'h48); issue(16'h4444, 1, 0, "R5 ext slot1");
    issue(16'hC444, 1, 0, "R12 allram slot3");
    // R7 shadow writes and region locks
    ctl(8'h00, 8'h00, 8'h00, 8'h00, 8'h00); issue(16'h4000, 0, 1, "R7 page5 open");
    ctl(8'h00, 8'h00, 8'h00, 8'h01, 8'h00); issue(16'h4000, 0, 1, "R7 page5 low lock");
    issue(16'h6000, 0, 1, "R7 page5 high open");
    ctl(8'h00, 8'h00, 8'h00, 8'h04, 8'h00); issue(16'h6000, 0, 1, "R7 high lock");
    ctl(8'h07, 8'h00, 8'h00, 8'h02, 8'h00); issue(16'hC100, 0, 1, "R7 page7 low lock");
    issue(16'hE100, 0, 1, "R7 page7 high open");
    ctl(8'h00, 8'h03, 8'h00, 8'h08, 8'h00); issue(16'h0100, 0, 1, "R7 page4 lock");
    issue(16'h8100, 0, 1, "R7 page6 lock");
    ctl(8'h06, 8'h00, 8'h00, 8'h00, 8'h08); issue(16'hC100, 0, 1, "R7 ext no shadow");
    // R6 main lock
    ctl(8'h00, 8'h00, 8'h00, 8'h10, 8'h00); issue(16'h4100, 0, 1, "R6 locked");
    issue(16'h8100, 0, 1, "R6 page2 free");
    // R8 redirect
    ctl(8'h00, 8'h00, 8'h00, 8'h20, 8'h00); issue(16'h4100, 1, 0, "R8 redirect");
    issue(16'h8100, 1, 0, "R8 page2 stays");
    issue(16'h4100, 0, 1, "R8 write unaffected");
    // R10 idle and R11 offset
    issue(16'h4100, 0, 0, "R10 idle");
    ctl(8'h05, 8'h00, 8'h00, 8'h00, 8'h00); issue(16'hEDCB, 1, 0, "R11 offset");
    issue(16'h0000, 0, 0, "R10 idle2");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule